// File: doc/BRIEF.md
# Two-Wavelength LED Timing Sequencer

This block produces the repeating timing frame for an optical sensor front end that lights a red and an infrared emitter in turn. A single-cycle `phase_tick` at the 15.36 kHz base rate moves a ten-position one-hot ring, so each position lasts about 65.1 µs and the full frame repeats every 651 µs. The red emitter is lit in position 0 and the infrared emitter in position 5. A short sample strobe falls in the middle third of each lit position. A grounding strobe shorts the front-end inputs in positions 3 and 8, which come shortly before each emitter pulse.

A second single-cycle input, `sub_tick`, runs at three times the base rate. It steps a mod-3 sub-slot counter that divides each position into three equal slots. Sub-slot 1 is the sample window, which gives a strobe of about 21.7 µs. A calibration input, `cal_hold`, forces the grounding strobe on for as long as it is set. All strobes are active low and are driven from registers, so none of them glitches at a position boundary. A one-clock `frame_start` pulse marks each wrap back to position 0.

Top module: `oxi_led_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, all four active-low strobes are high and `frame_start` is 0 after that edge. The ring returns to position 0 and the sub-slot counter to 0.
- R2: Each edge with `phase_tick` high moves the ring exactly one position (0→1→…→9). Without `phase_tick` the position holds. Exactly one position is active at any time.
- R3: A `phase_tick` in position 9 wraps the ring to position 0. After that same edge, `frame_start` is 1 for one clock; it is 0 at every other time.
- R4: `red_drive_n` is low after an edge exactly when the ring was in position 0 before that edge.
- R5: `ir_drive_n` is low after an edge exactly when the ring was in position 5 before that edge.
- R6: The sub-slot counter clears to 0 on `phase_tick`. Otherwise each `sub_tick` steps it 0→1→2→0, and `phase_tick` wins when both inputs are high. `sample_n` is low after an edge exactly when, before that edge, the ring was in position 0 or 5 and the sub-slot was 1.
- R7: `ground_n` is low after an edge when the ring was in position 3 or 8 before that edge.
- R8: When `cal_hold` is high at an edge, `ground_n` is low after that edge, whatever the ring position.
- R9: `red_drive_n` and `ir_drive_n` are never low together, and `sample_n` is low only while one of them is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_tick | input | 1 | Single-cycle base-rate (15.36 kHz) step |
| sub_tick | input | 1 | Single-cycle step at three times the base rate |
| cal_hold | input | 1 | Calibration override that forces grounding |
| red_drive_n | output | 1 | Red emitter drive, active low |
| ir_drive_n | output | 1 | Infrared emitter drive, active low |
| sample_n | output | 1 | Sample strobe, active low |
| ground_n | output | 1 | Input grounding strobe, active low |
| frame_start | output | 1 | One-clock pulse on wrap to position 0 |

## Verification
A tick changes the ring and sub-slot at the edge where it is sampled. The strobes reflect that new state one edge later, so a phase change reaches the outputs two edges after the tick is driven. `cal_hold` and `frame_start` act at the first edge. The driver keeps a position and sub-slot model of its own and, for each driven cycle, queues the output word that the next edge must produce from the model state and inputs as they stood before that edge. The monitor pops one word shortly after every rising edge and compares each strobe separately, so every result is checked in exactly the cycle it falls due.

// File: rtl/oxi_seq_pkg.sv
package oxi_seq_pkg;

    // Registered output word of the sequencer
    typedef struct packed {
        logic red_n;
        logic ir_n;
        logic sample_n;
        logic ground_n;
        logic frame_start;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{red_n: 1'b1, ir_n: 1'b1, sample_n: 1'b1,
                                        ground_n: 1'b1, frame_start: 1'b0};

endpackage

// File: rtl/oxi_phase_ring.sv
module oxi_phase_ring #(
    parameter int N_PHASES = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                phase_tick,
    output logic [N_PHASES-1:0] phase_q,
    output logic                wrap
);
    localparam logic [N_PHASES-1:0] RING_INIT = {{(N_PHASES-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [N_PHASES-1:0] ring;
    } ring_state_t;

    ring_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (phase_tick) begin
            st_d.ring = {st_q.ring[N_PHASES-2:0], st_q.ring[N_PHASES-1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ring <= RING_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_q = st_q.ring;
    assign wrap    = phase_tick & st_q.ring[N_PHASES-1];

    // R2: exactly one position active
    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(phase_q) == 1);

    // R2: position holds without a tick
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !phase_tick |=> $stable(phase_q));

    // R3: last position wraps to the first
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_tick && phase_q[N_PHASES-1]) |=> phase_q[0]);

endmodule

// File: rtl/oxi_subslot_ctr.sv
module oxi_subslot_ctr #(
    parameter int N_SLOTS = 3,
    parameter int SLOT_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phase_tick,
    input  logic              sub_tick,
    output logic [SLOT_W-1:0] slot_q
);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(N_SLOTS - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } slot_state_t;

    slot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (phase_tick) begin
            st_d.slot = '0;
        end else if (sub_tick) begin
            st_d.slot = (st_q.slot == SLOT_LAST) ? '0 : st_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.slot <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_q = st_q.slot;

    // R6: counter stays inside its range
    p_slot_range_r6: assert property (@(posedge clk) disable iff (rst)
        slot_q <= SLOT_LAST);

    // R6: the base-rate tick realigns the sub-slot
    p_slot_clear_r6: assert property (@(posedge clk) disable iff (rst)
        phase_tick |=> (slot_q == '0));

    // R6: no step without any tick
    p_slot_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!phase_tick && !sub_tick) |=> $stable(slot_q));

endmodule

// File: rtl/oxi_strobe_stage.sv
module oxi_strobe_stage
    import oxi_seq_pkg::*;
#(
    parameter int N_PHASES    = 10,
    parameter int SLOT_W      = 2,
    parameter int RED_PHASE   = 0,
    parameter int IR_PHASE    = 5,
    parameter int GND_PHASE_A = 3,
    parameter int GND_PHASE_B = 8,
    parameter int SAMPLE_SLOT = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_PHASES-1:0] phase,
    input  logic [SLOT_W-1:0]   slot,
    input  logic                wrap,
    input  logic                cal_hold,
    output strobe_t             out_q
);
    localparam logic [N_PHASES-1:0] GND_MASK =
        (N_PHASES'(1) << GND_PHASE_A) | (N_PHASES'(1) << GND_PHASE_B);
    localparam logic [N_PHASES-1:0] LED_MASK =
        (N_PHASES'(1) << RED_PHASE) | (N_PHASES'(1) << IR_PHASE);

    strobe_t out_d;
    logic    led_on;
    logic    in_window;
    logic    gnd_phase;

    always_comb begin
        led_on    = |(phase & LED_MASK);
        in_window = (slot == SLOT_W'(SAMPLE_SLOT));
        gnd_phase = |(phase & GND_MASK);

        out_d             = STROBE_IDLE;
        out_d.red_n       = ~phase[RED_PHASE];
        out_d.ir_n        = ~phase[IR_PHASE];
        out_d.sample_n    = ~(led_on & in_window);
        out_d.ground_n    = ~(gnd_phase | cal_hold);
        out_d.frame_start = wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= STROBE_IDLE;
        end else begin
            out_q <= out_d;
        end
    end

    // R8: override grounds the inputs at the next edge
    p_cal_ground_r8: assert property (@(posedge clk) disable iff (rst)
        cal_hold |=> !out_q.ground_n);

    // R7: grounding positions drive the strobe
    p_gnd_phase_r7: assert property (@(posedge clk) disable iff (rst)
        gnd_phase |=> !out_q.ground_n);

    // R3: frame pulse lasts a single clock
    p_frame_single_r3: assert property (@(posedge clk) disable iff (rst)
        out_q.frame_start |=> !out_q.frame_start);

endmodule

// File: rtl/oxi_led_sequencer.sv
module oxi_led_sequencer
    import oxi_seq_pkg::*;
#(
    parameter int N_PHASES    = 10,
    parameter int N_SLOTS     = 3,
    parameter int RED_PHASE   = 0,
    parameter int IR_PHASE    = 5,
    parameter int GND_PHASE_A = 3,
    parameter int GND_PHASE_B = 8,
    parameter int SAMPLE_SLOT = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic phase_tick,
    input  logic sub_tick,
    input  logic cal_hold,
    output logic red_drive_n,
    output logic ir_drive_n,
    output logic sample_n,
    output logic ground_n,
    output logic frame_start
);
    localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

    logic [N_PHASES-1:0] phase_q;
    logic [SLOT_W-1:0]   slot_q;
    logic                wrap;
    strobe_t             strobes_q;

    oxi_phase_ring #(
        .N_PHASES (N_PHASES)
    ) u_ring (
        .clk        (clk),
        .rst        (rst),
        .phase_tick (phase_tick),
        .phase_q    (phase_q),
        .wrap       (wrap)
    );

    oxi_subslot_ctr #(
        .N_SLOTS (N_SLOTS),
        .SLOT_W  (SLOT_W)
    ) u_slot (
        .clk        (clk),
        .rst        (rst),
        .phase_tick (phase_tick),
        .sub_tick   (sub_tick),
        .slot_q     (slot_q)
    );

    oxi_strobe_stage #(
        .N_PHASES    (N_PHASES),
        .SLOT_W      (SLOT_W),
        .RED_PHASE   (RED_PHASE),
        .IR_PHASE    (IR_PHASE),
        .GND_PHASE_A (GND_PHASE_A),
        .GND_PHASE_B (GND_PHASE_B),
        .SAMPLE_SLOT (SAMPLE_SLOT)
    ) u_strobe (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase_q),
        .slot     (slot_q),
        .wrap     (wrap),
        .cal_hold (cal_hold),
        .out_q    (strobes_q)
    );

    assign red_drive_n = strobes_q.red_n;
    assign ir_drive_n  = strobes_q.ir_n;
    assign sample_n    = strobes_q.sample_n;
    assign ground_n    = strobes_q.ground_n;
    assign frame_start = strobes_q.frame_start;

    // R9: the two emitters never light together
    p_led_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(!red_drive_n && !ir_drive_n));

    // R9: sampling only inside an emitter pulse
    p_sample_inside_r9: assert property (@(posedge clk) disable iff (rst)
        !sample_n |-> (!red_drive_n || !ir_drive_n));

    // R4: red strobe follows the ring position one edge later
    p_red_follow_r4: assert property (@(posedge clk) disable iff (rst)
        phase_q[RED_PHASE] |=> !red_drive_n);

    // R1: reset leaves every strobe idle
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (red_drive_n && ir_drive_n && sample_n && ground_n && !frame_start));

endmodule

// File: tb/test_oxi_led_sequencer.sv
module test_oxi_led_sequencer;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic phase_tick = 1'b0;
    logic sub_tick = 1'b0;
    logic cal_hold = 1'b0;
    logic red_drive_n, ir_drive_n, sample_n, ground_n, frame_start;

    always #5 clk = ~clk;

    oxi_led_sequencer i_oxi_led_sequencer (
        .clk         (clk),
        .rst         (rst),
        .phase_tick  (phase_tick),
        .sub_tick    (sub_tick),
        .cal_hold    (cal_hold),
        .red_drive_n (red_drive_n),
        .ir_drive_n  (ir_drive_n),
        .sample_n    (sample_n),
        .ground_n    (ground_n),
        .frame_start (frame_start)
    );

    // expected word: {red, ir, sample, ground, fs, cal, rst}
    logic [6:0] sb[$];
    int total = 0;
    int bad   = 0;
    int m_phase = 0;
    int m_slot  = 0;
    bit done = 0;

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic r, input logic t, input logic s, input logic c);
        logic [4:0] e;
        @(negedge clk);
        rst = r; phase_tick = t; sub_tick = s; cal_hold = c;
        if (r) begin
            e = 5'b11110;
            m_phase = 0;
            m_slot  = 0;
        end else begin
            e[4] = !(m_phase == 0);
            e[3] = !(m_phase == 5);
            e[2] = !((m_phase == 0 || m_phase == 5) && m_slot == 1);
            e[1] = !(m_phase == 3 || m_phase == 8 || c);
            e[0] = t && (m_phase == 9);
            if (t) begin
                m_phase = (m_phase + 1) % 10;
                m_slot  = 0;
            end else if (s) begin
                m_slot = (m_slot + 1) % 3;
            end
        end
        sb.push_back({e, c, r});
    endtask

    // monitor: one expected word per edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                logic [6:0] it;
                it = sb.pop_front();
                if (it[0]) begin
                    chk("R1 red", red_drive_n, it[6]);
                    chk("R1 ir", ir_drive_n, it[5]);
                    chk("R1 sample", sample_n, it[4]);
                    chk("R1 ground", ground_n, it[3]);
                    chk("R1 frame", frame_start, it[2]);
                end else begin
                    chk("R2 R4 red", red_drive_n, it[6]);
                    chk("R2 R5 ir", ir_drive_n, it[5]);
                    chk("R6 sample", sample_n, it[4]);
                    chk(it[1] ? "R8 ground" : "R7 ground", ground_n, it[3]);
                    chk("R3 frame", frame_start, it[2]);
                    chk("R9 exclusive", !(!red_drive_n && !ir_drive_n), 1'b1);
                end
            end
        end
    end

    // watchdog
    initial begin
        #1_000_000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) drive(1, 0, 0, 0);
        // R6 nominal: tick, sub (window), sub, per phase, two frames
        for (int p = 0; p < 20; p++) begin
            drive(0, 0, 1, 0);
            drive(0, 0, 0, 0);
            drive(0, 0, 1, 0);
            drive(0, 1, 0, 0);
        end
        // R2 R3: back-to-back ticks, no sub-ticks
        for (int i = 0; i < 12; i++) drive(0, 1, 0, 0);
        // R6: sub-slot wraps mod 3; tick and sub together
        for (int p = 0; p < 10; p++) begin
            for (int k = 0; k < 4 + (p % 4); k++) drive(0, 0, 1, 0);
            drive(0, 1, (p % 2) == 1, 0);
        end
        // R8: calibration hold across many positions
        for (int p = 0; p < 6; p++) begin
            drive(0, 0, 1, 1);
            drive(0, 0, 1, 1);
            drive(0, 1, 0, 1);
        end
        drive(0, 0, 0, 0);
        // R1: reset mid-frame, then resume
        for (int p = 0; p < 3; p++) drive(0, 1, 0, 0);
        drive(1, 1, 1, 1);
        drive(1, 0, 0, 0);
        for (int p = 0; p < 12; p++) begin
            drive(0, 0, 1, 0);
            drive(0, 1, 0, 0);
        end
        for (int i = 0; i < 4; i++) drive(0, 0, 0, 0);
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule